// File: doc/BRIEF.md
# Cartridge Image Loader with Per-Segment CRC-16

This block takes a cartridge image as a stream of bytes, one per accepted valid/ready handshake, and unpacks it into a 64K-word memory through a write port. The image opens with a marker byte and a segment count that is protected by its complement. A series of segments follows. Each segment names a page range by its upper address bytes and carries one 16-bit word for every address in that range, sent as two bytes, high byte first. Each segment ends with a big-endian CRC-16 check value that covers its bound bytes and its data bytes.

After the last segment, a fixed table of raw bytes is passed through a separate strobe port together with each byte's index. This table carries its own CRC-16 check value. When the whole image is accepted and every check matches, the block raises `done`. When any check fails, the block raises `error` and stops taking input. In both cases the block stays in that state until reset.

Top module: `cart_loader`

## Requirements
- R1: After reset, `in_ready` is high, and `done`, `error`, `wr_en` and `tbl_we` are low.
- R2: If the first byte is not 0xA8, `error` rises and no later byte is accepted.
- R3: The second byte is the segment count. If the third byte is not its bitwise complement, `error` rises after exactly three accepted bytes.
- R4: A segment opens with two bytes: the upper start byte S, then the upper end byte E. The segment covers word addresses S*256 through E*256+255, and S = E is a valid one-page range. If E < S, `error` rises when E is accepted.
- R5: Each word of a segment comes as a high byte, then a low byte. Its address is the next one in the range, counting upward from the start. One cycle after the low byte is accepted, `wr_en` pulses for one cycle with that address and the data {high, low}. This holds up to and including address 0xFFFF.
- R6: The segment CRC is CRC-16 with polynomial 0x1021, processed MSB first. It restarts at 0xFFFF for each segment and runs over the two bound bytes and all data bytes in stream order. The two bytes after the data are the expected value, high byte first. A mismatch raises `error` when the low byte is accepted.
- R7: After the segments come 48 table bytes. Each one pulses `tbl_we` one cycle after it is accepted, with `tbl_idx` running from 0 to 47 and `tbl_byte` equal to the byte. The table CRC restarts at 0xFFFF, uses the same polynomial, and is followed by a big-endian expected value. A mismatch raises `error`.
- R8: When every check passes, `done` rises as the final CRC byte is accepted. `done` then stays high with `in_ready` low, and `done` and `error` are never high together.
- R9: Once `error` is high, it stays high. `in_ready` is low and no `wr_en` or `tbl_we` pulse follows.
- R10: A segment count of 0 (with third byte 0xFF) goes straight to the table.
- R11: A byte is taken only when `in_valid` and `in_ready` are both high. Idle cycles between bytes change neither the result nor the writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | Image byte present |
| in_ready | output | 1 | Block will take a byte this cycle |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 16 | Memory word address |
| wr_data | output | 16 | Memory word data |
| tbl_we | output | 1 | Table byte strobe |
| tbl_idx | output | 6 | Table byte index |
| tbl_byte | output | 8 | Table byte value |
| done | output | 1 | Image loaded and verified |
| error | output | 1 | Image rejected |

## Verification
Whole images are built in the bench with a reference CRC written in a different form: the byte is XORed into the high half of the register and the register is then shifted eight times. Good images are sent with one-page, two-page and top-of-memory segments, with no segments, and with idle gaps between bytes. These show that address sequencing, byte order, the CRC restarts and the handshake are independent of one another. Single-fault images each corrupt one field: the marker, the count complement, the bound order, the CRC of a later segment, or the table CRC. The number of bytes accepted before `error` rises shows which check fired and when. The writes already issued, with nothing written after the failure, confirm that the block stops where it should.

// File: rtl/loader_pkg.sv
package loader_pkg;

  typedef enum logic [3:0] {
    ST_MAGIC,
    ST_COUNT,
    ST_CHECK,
    ST_SEG_S,
    ST_SEG_E,
    ST_D_HI,
    ST_D_LO,
    ST_C_HI,
    ST_C_LO,
    ST_TBL,
    ST_T_HI,
    ST_T_LO,
    ST_DONE,
    ST_FAIL
  } load_state_t;

  // One byte of CRC-16, MSB first, bit-serial form
  function automatic logic [15:0] crc16_step(input logic [15:0] crc,
                                             input logic [7:0]  b,
                                             input logic [15:0] poly);
    logic [15:0] c;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      if (c[15] ^ b[i]) c = {c[14:0], 1'b0} ^ poly;
      else              c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/loader_crc.sv
module loader_crc #(
  parameter logic [15:0] CRC_INIT = 16'hFFFF,
  parameter logic [15:0] CRC_POLY = 16'h1021
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        update,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import loader_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)       crc <= CRC_INIT;
    else if (restart) crc <= crc16_step(CRC_INIT, din, CRC_POLY);
    else if (update)  crc <= crc16_step(crc, din, CRC_POLY);
  end
endmodule

// File: rtl/loader_addr.sv
module loader_addr #(
  parameter int ADDR_W = 16,
  localparam int PAGE_W = ADDR_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] end_pg,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] last_addr,
  output logic              at_end
);
  logic [PAGE_W-1:0] s_q, e_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      s_q  <= '0;
      e_q  <= '0;
    end else if (load) begin
      addr <= {start_pg, 8'h00};
      s_q  <= start_pg;
      e_q  <= end_pg;
    end else if (step) begin
      addr <= addr + 1'b1;
    end
  end

  assign first_addr = {s_q, 8'h00};
  assign last_addr  = {e_q, 8'hFF};
  assign at_end     = (addr == last_addr);
endmodule

// File: rtl/loader_ctrl.sv
module loader_ctrl #(
  parameter logic [7:0] MAGIC     = 8'hA8,
  parameter int         TABLE_LEN = 48,
  parameter int         ADDR_W    = 16,
  localparam int        IDX_W     = $clog2(TABLE_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       crc_now,
  output logic              crc_restart,
  output logic              crc_update,
  input  logic [ADDR_W-1:0] addr_now,
  input  logic              at_end,
  output logic              addr_load,
  output logic              addr_step,
  output logic [7:0]        start_pg,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [15:0]       wr_data,
  output logic              tbl_we,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic [7:0]        tbl_byte,
  output logic              done,
  output logic              error,
  output logic              accept,
  output logic              fault
);
  import loader_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TABLE_LEN - 1);

  load_state_t      state, state_nxt;
  logic [7:0]       seg_left;
  logic [7:0]       hold;
  logic [IDX_W-1:0] idx;
  logic             crc_match;

  assign in_ready  = (state != ST_DONE) && (state != ST_FAIL);
  assign accept    = in_valid && in_ready;
  assign crc_match = ({hold, in_data} == crc_now);
  assign done      = (state == ST_DONE);
  assign error     = (state == ST_FAIL);

  always_comb begin
    fault = 1'b0;
    if (accept) begin
      case (state)
        ST_MAGIC: fault = (in_data != MAGIC);
        ST_CHECK: fault = (in_data != ~seg_left);
        ST_SEG_E: fault = (in_data < start_pg);
        ST_C_LO:  fault = !crc_match;
        ST_T_LO:  fault = !crc_match;
        default:  fault = 1'b0;
      endcase
    end
  end

  assign crc_restart = accept && ((state == ST_SEG_S) ||
                                  (state == ST_TBL && idx == '0));
  assign crc_update  = accept && ((state == ST_SEG_E) || (state == ST_D_HI) ||
                                  (state == ST_D_LO) ||
                                  (state == ST_TBL && idx != '0));
  assign addr_load   = accept && (state == ST_SEG_E) && !fault;
  assign addr_step   = accept && (state == ST_D_LO);

  always_comb begin
    state_nxt = state;
    if (fault) begin
      state_nxt = ST_FAIL;
    end else if (accept) begin
      case (state)
        ST_MAGIC: state_nxt = ST_COUNT;
        ST_COUNT: state_nxt = ST_CHECK;
        ST_CHECK: state_nxt = (seg_left == 8'd0) ? ST_TBL : ST_SEG_S;
        ST_SEG_S: state_nxt = ST_SEG_E;
        ST_SEG_E: state_nxt = ST_D_HI;
        ST_D_HI:  state_nxt = ST_D_LO;
        ST_D_LO:  state_nxt = at_end ? ST_C_HI : ST_D_HI;
        ST_C_HI:  state_nxt = ST_C_LO;
        ST_C_LO:  state_nxt = (seg_left == 8'd1) ? ST_TBL : ST_SEG_S;
        ST_TBL:   state_nxt = (idx == LAST_IDX) ? ST_T_HI : ST_TBL;
        ST_T_HI:  state_nxt = ST_T_LO;
        ST_T_LO:  state_nxt = ST_DONE;
        default:  state_nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_MAGIC;
      seg_left <= '0;
      start_pg <= '0;
      hold     <= '0;
      idx      <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      tbl_we   <= 1'b0;
      tbl_idx  <= '0;
      tbl_byte <= '0;
    end else begin
      state  <= state_nxt;
      wr_en  <= 1'b0;
      tbl_we <= 1'b0;
      if (accept) begin
        case (state)
          ST_COUNT: seg_left <= in_data;
          ST_SEG_S: start_pg <= in_data;
          ST_D_HI, ST_C_HI, ST_T_HI: hold <= in_data;
          ST_D_LO: begin
            wr_en   <= 1'b1;
            wr_addr <= addr_now;
            wr_data <= {hold, in_data};
          end
          ST_C_LO: seg_left <= seg_left - 8'd1;
          ST_TBL: begin
            tbl_we   <= 1'b1;
            tbl_idx  <= idx;
            tbl_byte <= in_data;
            idx      <= idx + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cart_loader.sv
module cart_loader #(
  parameter logic [7:0]  MAGIC     = 8'hA8,
  parameter int          TABLE_LEN = 48,
  parameter logic [15:0] CRC_INIT  = 16'hFFFF,
  parameter logic [15:0] CRC_POLY  = 16'h1021,
  localparam int         ADDR_W    = 16,
  localparam int         IDX_W     = $clog2(TABLE_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [15:0]       wr_data,
  output logic              tbl_we,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic [7:0]        tbl_byte,
  output logic              done,
  output logic              error
);
  logic [15:0]       crc_now;
  logic              crc_restart, crc_update;
  logic [ADDR_W-1:0] addr_now, seg_first, seg_last;
  logic              at_end, addr_load, addr_step;
  logic [7:0]        start_pg;
  logic              ev_accept, ev_fault;

  loader_crc #(.CRC_INIT(CRC_INIT), .CRC_POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .restart(crc_restart), .update(crc_update),
    .din(in_data), .crc(crc_now)
  );

  loader_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .step(addr_step),
    .start_pg(start_pg), .end_pg(in_data), .addr(addr_now),
    .first_addr(seg_first), .last_addr(seg_last), .at_end(at_end)
  );

  loader_ctrl #(.MAGIC(MAGIC), .TABLE_LEN(TABLE_LEN), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .crc_now(crc_now), .crc_restart(crc_restart),
    .crc_update(crc_update), .addr_now(addr_now), .at_end(at_end),
    .addr_load(addr_load), .addr_step(addr_step), .start_pg(start_pg),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .tbl_we(tbl_we),
    .tbl_idx(tbl_idx), .tbl_byte(tbl_byte), .done(done), .error(error),
    .accept(ev_accept), .fault(ev_fault)
  );
endmodule

// File: rtl/loader_checker.sv
module loader_checker #(
  parameter int  TABLE_LEN = 48,
  localparam int IDX_W     = $clog2(TABLE_LEN)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             wr_en,
  input logic [15:0]      wr_addr,
  input logic             tbl_we,
  input logic [IDX_W-1:0] tbl_idx,
  input logic             done,
  input logic             error,
  input logic [15:0]      seg_first,
  input logic [15:0]      seg_last,
  input logic             ev_fault
);
  assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);
  assert_error_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!in_ready && !wr_en && !tbl_we));
  assert_fault_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> error);
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !in_ready));
  assert_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  assert_write_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr >= seg_first && wr_addr <= seg_last));
  assert_idle_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!wr_en && !tbl_we));
  assert_tbl_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> (tbl_idx < IDX_W'(TABLE_LEN)));
endmodule

bind cart_loader loader_checker #(.TABLE_LEN(TABLE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .wr_en(wr_en), .wr_addr(wr_addr), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
  .done(done), .error(error), .seg_first(seg_first), .seg_last(seg_last),
  .ev_fault(ev_fault)
);

// File: tb/test_cart_loader.sv
module test_cart_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready, wr_en, tbl_we, done, error;
  logic [15:0] wr_addr, wr_data;
  logic [5:0]  tbl_idx;
  logic [7:0]  tbl_byte;

  int errors = 0;
  int checks = 0;
  int accepted = 0;
  bit finished = 0;

  logic [7:0]  img[$];
  logic [31:0] exp_w[$];
  logic [13:0] exp_t[$];

  always #2 clk = ~clk;

  cart_loader i_cart_loader (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_byte(tbl_byte),
    .done(done), .error(error)
  );

  function automatic logic [15:0] ref_crc(logic [15:0] c, logic [7:0] b);
    c = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    return c;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_w.size() == 0) check(0, "R9", "unexpected write", int'(wr_addr), 0);
      else begin
        logic [31:0] e;
        e = exp_w.pop_front();
        check({wr_addr, wr_data} == e, "R5", "write addr/data", {wr_addr, wr_data}, e);
      end
    end
    if (rst_n && tbl_we) begin
      if (exp_t.size() == 0) check(0, "R9", "unexpected table strobe", int'(tbl_idx), 0);
      else begin
        logic [13:0] t;
        t = exp_t.pop_front();
        check({tbl_idx, tbl_byte} == t, "R7", "table idx/byte", {tbl_idx, tbl_byte}, t);
      end
    end
  end

  task automatic do_reset();
    img.delete(); exp_w.delete(); exp_t.delete();
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic put_header(int n, bit bad_magic, bit bad_cnt);
    img.push_back(bad_magic ? 8'hA9 : 8'hA8);
    img.push_back(8'(n));
    img.push_back(bad_cnt ? 8'(n) : ~8'(n));
  endtask

  task automatic put_seg(logic [7:0] us, logic [7:0] ue, logic [7:0] seed, bit bad_crc);
    logic [15:0] c, d;
    c = 16'hFFFF;
    img.push_back(us); c = ref_crc(c, us);
    img.push_back(ue); c = ref_crc(c, ue);
    for (int a = {us, 8'h00}; a <= {ue, 8'hFF}; a++) begin
      d = 16'(a) ^ {seed, ~seed};
      img.push_back(d[15:8]); c = ref_crc(c, d[15:8]);
      img.push_back(d[7:0]);  c = ref_crc(c, d[7:0]);
      exp_w.push_back({16'(a), d});
    end
    img.push_back(c[15:8]);
    img.push_back(c[7:0] ^ {7'd0, bad_crc});
  endtask

  task automatic put_table(logic [7:0] seed, bit bad_crc);
    logic [15:0] c;
    logic [7:0]  b;
    c = 16'hFFFF;
    for (int i = 0; i < 48; i++) begin
      b = 8'(i * 7) + seed;
      img.push_back(b); c = ref_crc(c, b);
      exp_t.push_back({6'(i), b});
    end
    img.push_back(c[15:8]);
    img.push_back(c[7:0] ^ {7'd0, bad_crc});
  endtask

  task automatic run(int gap);
    accepted = 0;
    for (int k = 0; k < img.size(); k++) begin
      @(negedge clk);
      in_data = img[k];
      in_valid = 1'b1;
      if (!in_ready) begin
        in_valid = 1'b0;
        return;
      end
      @(posedge clk);
      accepted++;
      if (gap > 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_check(string req, bit exp_done, bit exp_err, int exp_acc);
    repeat (3) @(negedge clk);
    check(done == exp_done, req, "done", done, exp_done);
    check(error == exp_err, req, "error", error, exp_err);
    check(accepted == exp_acc, req, "bytes accepted", accepted, exp_acc);
    check(exp_w.size() == 0, req, "writes outstanding", exp_w.size(), 0);
    check(exp_t.size() == 0, req, "table strobes outstanding", exp_t.size(), 0);
    if (exp_err) begin
      in_valid = 1'b1;
      in_data = 8'hA8;
      repeat (8) @(negedge clk);
      check(!in_ready && error, "R9", "ready after error", in_ready, 0);
      in_valid = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    check(0, "WDOG", "watchdog expired", 0, 1);
    if (!finished) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    // R1 reset state
    do_reset();
    check(in_ready && !done && !error && !wr_en && !tbl_we, "R1", "reset outputs",
          {in_ready, done, error, wr_en, tbl_we}, 5'b10000);

    // R5 R6 R7 R8: two good segments
    do_reset();
    put_header(2, 0, 0);
    put_seg(8'h10, 8'h10, 8'h3C, 0);
    put_seg(8'h20, 8'h21, 8'h5A, 0);
    put_table(8'h11, 0);
    n = img.size();
    run(0);
    finish_check("R8", 1, 0, n);

    // R11 R5: gaps between bytes, top-of-memory segment
    do_reset();
    put_header(2, 0, 0);
    put_seg(8'h00, 8'h00, 8'hC3, 0);
    put_seg(8'hFF, 8'hFF, 8'h96, 0);
    put_table(8'h80, 0);
    n = img.size();
    run(2);
    finish_check("R11", 1, 0, n);

    // R10 zero segments
    do_reset();
    put_header(0, 0, 0);
    put_table(8'h02, 0);
    n = img.size();
    run(0);
    finish_check("R10", 1, 0, n);

    // R2 bad marker
    do_reset();
    put_header(1, 1, 0);
    run(0);
    finish_check("R2", 0, 1, 1);

    // R3 count complement mismatch
    do_reset();
    put_header(3, 0, 1);
    run(1);
    finish_check("R3", 0, 1, 3);

    // R4 end below start
    do_reset();
    put_header(1, 0, 0);
    img.push_back(8'h05);
    img.push_back(8'h04);
    run(0);
    finish_check("R4", 0, 1, 5);

    // R6 bad CRC on second segment
    do_reset();
    put_header(2, 0, 0);
    put_seg(8'h40, 8'h40, 8'h01, 0);
    put_seg(8'h41, 8'h42, 8'h02, 1);
    n = img.size();
    put_table(8'h00, 0);
    exp_t.delete();
    run(0);
    finish_check("R6", 0, 1, n);

    // R7 bad table CRC
    do_reset();
    put_header(1, 0, 0);
    put_seg(8'h7F, 8'h7F, 8'hEE, 0);
    put_table(8'h33, 1);
    n = img.size();
    run(0);
    finish_check("R7", 0, 1, n);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule